// File: doc/BRIEF.md
# Sub-page peripheral address demultiplexer

This block divides one page of memory-mapped address space into equal slots of 256 bytes. It steers each access to the peripheral that owns the slot. A small table holds one target code per slot. Software fills the table through a configuration port. Each configuration request names a start offset, a length in bytes and a target code. Every slot that the byte range touches is then given to that target.

An access carries a full address. The block subtracts the page base, takes the slot index from the page-relative offset and looks up the owner. It then raises that owner's select line. The access width, write enable, write data and the page-relative offset go to the targets unchanged. Read data comes back from the selected target's lane. Target code 0 is an internal default responder. Every slot belongs to it after reset. It returns zero on reads, drops writes and flags the access as unmapped.

The configuration port is tracked by a three-state machine. CFG_IDLE means no request was made in the previous cycle. CFG_ACCEPT means the previous request was valid and written. CFG_REJECT means the previous request was refused. The transitions are the same from every state:
- A valid request moves to CFG_ACCEPT.
- A refused request moves to CFG_REJECT.
- No request returns to CFG_IDLE.

Top module: `subpage_demux`

## Requirements
- R1: After reset every slot belongs to the default responder (code 0), so any access reports unmapped with zero read data and no select raised.
- R2: The slot index is bits [11:8] of (acc_addr minus PAGE_BASE). During an access, the select bit i-1 rises only when the slot's owner is target i (1..15). At most one select is high, and none is high when no access is presented.
- R3: An accepted request writes its target code into every slot from index (offset>>8) through index ((offset+length-1)>>8) inclusive, and into no other slot.
- R4: A request with length 0, or with offset plus length above 4096, is refused. cfg_err pulses for one cycle in the cycle after the request, and the table is left unchanged.
- R5: An accepted request pulses cfg_ack in the cycle after it. The new mapping applies to accesses from that cycle on. An access presented in the same cycle as the request is routed with the old mapping.
- R6: tgt_addr carries the 12-bit page-relative offset. tgt_size (0 byte, 1 halfword, 2 word), tgt_we and tgt_wdata carry the access values unchanged for every width.
- R7: An access to a slot owned by code 0 raises acc_unmapped for that cycle, returns zero read data and raises no select, so the write reaches no target.
- R8: A mapped access returns on acc_rdata the lane of tgt_rdata belonging to its owner: bits [(i-1)*32 +: 32] for target i.
- R9: A request with target code 0 hands its slots back to the default responder.
- R10: cfg_ack and cfg_err are never high together, and both are low in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Range registration request |
| cfg_offset | input | 13 | Start offset of the range within the page |
| cfg_len | input | 13 | Range length in bytes |
| cfg_tgt | input | 4 | Target code to assign (0 = default responder) |
| cfg_ack | output | 1 | Previous-cycle request accepted |
| cfg_err | output | 1 | Previous-cycle request refused |
| acc_valid | input | 1 | Access present |
| acc_we | input | 1 | Access is a write |
| acc_size | input | 2 | Access width code |
| acc_addr | input | 32 | Full access address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data returned |
| acc_unmapped | output | 1 | Access hit a slot owned by the default responder |
| tgt_sel | output | 15 | One select per target 1..15 (bit i-1 for target i) |
| tgt_we | output | 1 | Forwarded write enable |
| tgt_size | output | 2 | Forwarded width code |
| tgt_addr | output | 12 | Page-relative offset |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 480 | Read data lanes, 32 bits per target |

## Verification
The assertions check on every cycle that at most one select is high. They check that an unmapped access stays silent, that each slot changes only when an accepted request covers it, and that every acknowledge or error pulse follows a request of the matching kind. Only the bench scenarios can show the actual owner chosen for a given address. The same holds for the inclusive end-slot arithmetic when a range crosses a slot boundary, for the refusal of ranges that end exactly one byte past the page, and for the old mapping applying in the request cycle while the new one applies in the next.

// File: rtl/demux_pkg.sv
package demux_pkg;
    typedef enum logic [1:0] {
        CFG_IDLE   = 2'd0,
        CFG_ACCEPT = 2'd1,
        CFG_REJECT = 2'd2
    } cfg_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/demux_range_chk.sv
module demux_range_chk #(
    parameter int PAGE_BITS = 12,
    parameter int SLOT_BITS = 8,
    localparam int IDX_W    = PAGE_BITS - SLOT_BITS
) (
    input  logic [PAGE_BITS:0] offset,
    input  logic [PAGE_BITS:0] len,
    output logic               ok,
    output logic [IDX_W-1:0]   first_idx,
    output logic [IDX_W-1:0]   last_idx
);
    localparam int SUM_W = PAGE_BITS + 2;
    localparam logic [SUM_W-1:0] PAGE_SIZE = SUM_W'(1) << PAGE_BITS;

    logic [SUM_W-1:0] end_excl;
    logic [SUM_W-1:0] end_incl;

    always_comb begin
        end_excl  = SUM_W'(offset) + SUM_W'(len);
        end_incl  = end_excl - SUM_W'(1);
        ok        = (len != '0) && (end_excl <= PAGE_SIZE);
        first_idx = IDX_W'(offset >> SLOT_BITS);
        last_idx  = IDX_W'(end_incl >> SLOT_BITS);
    end
endmodule

// File: rtl/demux_cfg_fsm.sv
module demux_cfg_fsm
    import demux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_valid,
    input  logic cfg_ok,
    output logic cfg_ack,
    output logic cfg_err
);
    cfg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = CFG_IDLE;
        unique case (state_q)
            CFG_IDLE, CFG_ACCEPT, CFG_REJECT: begin
                if (cfg_valid) state_d = cfg_ok ? CFG_ACCEPT : CFG_REJECT;
                else           state_d = CFG_IDLE;
            end
            default: state_d = CFG_IDLE;
        endcase
    end

    always_comb begin
        cfg_ack = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            CFG_IDLE:   ;
            CFG_ACCEPT: cfg_ack = 1'b1;
            CFG_REJECT: cfg_err = 1'b1;
            default:    ;
        endcase
    end

    AST_ACK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_ok |=> cfg_ack); // R5
    AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ok |=> cfg_err); // R4
    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !cfg_ack && !cfg_err); // R10
endmodule

// File: rtl/demux_slot_table.sv
module demux_slot_table #(
    parameter int IDX_W = 4,
    parameter int TGT_W = 4,
    localparam int NUM_SLOTS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TGT_W-1:0] rd_tgt
);
    logic [TGT_W-1:0] slot_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic covered;
        assign covered = (IDX_W'(s) >= first_idx) && (IDX_W'(s) <= last_idx);

        always_ff @(posedge clk) begin
            if (!rst_n)                 slot_q[s] <= '0;
            else if (wr_en && covered)  slot_q[s] <= wr_tgt;
        end

        AST_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && (IDX_W'(s) >= first_idx) && (IDX_W'(s) <= last_idx)
            |=> slot_q[s] == $past(wr_tgt)); // R3
        AST_SLOT_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && ((IDX_W'(s) < first_idx) || (IDX_W'(s) > last_idx))
            |=> $stable(slot_q[s])); // R3
        AST_SLOT_NO_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(slot_q[s])); // R4
    end

    assign rd_tgt = slot_q[rd_idx];
endmodule

// File: rtl/demux_router.sv
module demux_router #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SLOT_BITS = 8,
    parameter int TGT_W     = 4,
    parameter logic [ADDR_W-1:0] PAGE_BASE = '0,
    localparam int IDX_W    = PAGE_BITS - SLOT_BITS,
    localparam int NUM_EXT  = (1 << TGT_W) - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [ADDR_W-1:0]        acc_addr,
    output logic [IDX_W-1:0]         slot_idx,
    output logic [PAGE_BITS-1:0]     page_off,
    input  logic [TGT_W-1:0]         owner,
    output logic [NUM_EXT-1:0]       tgt_sel,
    input  logic [NUM_EXT*DATA_W-1:0] tgt_rdata,
    output logic [DATA_W-1:0]        acc_rdata,
    output logic                     acc_unmapped
);
    assign page_off = PAGE_BITS'(acc_addr - PAGE_BASE);
    assign slot_idx = IDX_W'(page_off >> SLOT_BITS);

    for (genvar t = 1; t <= NUM_EXT; t++) begin : g_sel
        assign tgt_sel[t-1] = acc_valid && (owner == TGT_W'(t));
    end

    always_comb begin
        acc_rdata = '0;
        for (int t = 0; t < NUM_EXT; t++) begin
            if (tgt_sel[t]) acc_rdata = acc_rdata | tgt_rdata[t*DATA_W +: DATA_W];
        end
    end

    assign acc_unmapped = acc_valid && (owner == '0);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)); // R2
    AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_unmapped |-> (tgt_sel == '0) && (acc_rdata == '0)); // R7
    AST_NO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (tgt_sel == '0) && !acc_unmapped); // R2
endmodule

// File: rtl/subpage_demux.sv
module subpage_demux #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SLOT_BITS = 8,
    parameter int TGT_W     = 4,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 32'hEF60_0000,
    localparam int IDX_W    = PAGE_BITS - SLOT_BITS,
    localparam int NUM_EXT  = (1 << TGT_W) - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_valid,
    input  logic [PAGE_BITS:0]        cfg_offset,
    input  logic [PAGE_BITS:0]        cfg_len,
    input  logic [TGT_W-1:0]          cfg_tgt,
    output logic                      cfg_ack,
    output logic                      cfg_err,
    input  logic                      acc_valid,
    input  logic                      acc_we,
    input  logic [1:0]                acc_size,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [DATA_W-1:0]         acc_wdata,
    output logic [DATA_W-1:0]         acc_rdata,
    output logic                      acc_unmapped,
    output logic [NUM_EXT-1:0]        tgt_sel,
    output logic                      tgt_we,
    output logic [1:0]                tgt_size,
    output logic [PAGE_BITS-1:0]      tgt_addr,
    output logic [DATA_W-1:0]         tgt_wdata,
    input  logic [NUM_EXT*DATA_W-1:0] tgt_rdata
);
    logic             range_ok;
    logic [IDX_W-1:0] first_idx, last_idx, slot_idx;
    logic [TGT_W-1:0] owner;

    demux_range_chk #(.PAGE_BITS(PAGE_BITS), .SLOT_BITS(SLOT_BITS)) u_chk (
        .offset(cfg_offset), .len(cfg_len), .ok(range_ok),
        .first_idx(first_idx), .last_idx(last_idx)
    );

    demux_cfg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ok(range_ok),
        .cfg_ack(cfg_ack), .cfg_err(cfg_err)
    );

    demux_slot_table #(.IDX_W(IDX_W), .TGT_W(TGT_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_valid && range_ok),
        .first_idx(first_idx), .last_idx(last_idx), .wr_tgt(cfg_tgt),
        .rd_idx(slot_idx), .rd_tgt(owner)
    );

    demux_router #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
        .SLOT_BITS(SLOT_BITS), .TGT_W(TGT_W), .PAGE_BASE(PAGE_BASE)
    ) u_rt (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .slot_idx(slot_idx), .page_off(tgt_addr), .owner(owner),
        .tgt_sel(tgt_sel), .tgt_rdata(tgt_rdata), .acc_rdata(acc_rdata),
        .acc_unmapped(acc_unmapped)
    );

    assign tgt_we    = acc_we;
    assign tgt_size  = acc_size;
    assign tgt_wdata = acc_wdata;

    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ack && cfg_err)); // R10
endmodule

// File: tb/sim_subpage_demux.sv
`timescale 1ns/1ps
module sim_subpage_demux;
    localparam int ADDR_W = 32, DATA_W = 32, PAGE_BITS = 12, SLOT_BITS = 8, TGT_W = 4;
    localparam int NUM_EXT = 15;
    localparam logic [31:0] BASE = 32'hEF60_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [12:0] cfg_offset = '0, cfg_len = '0;
    logic [3:0] cfg_tgt = '0;
    logic cfg_ack, cfg_err;
    logic acc_valid = 1'b0, acc_we = 1'b0;
    logic [1:0] acc_size = '0;
    logic [31:0] acc_addr = BASE, acc_wdata = '0, acc_rdata;
    logic acc_unmapped;
    logic [NUM_EXT-1:0] tgt_sel;
    logic tgt_we;
    logic [1:0] tgt_size;
    logic [11:0] tgt_addr;
    logic [31:0] tgt_wdata;
    logic [NUM_EXT*DATA_W-1:0] tgt_rdata;

    int checks = 0, errors = 0;
    logic [3:0] model [16];

    always #4 clk = ~clk;

    function automatic logic [31:0] lane_word(int i);
        return 32'hC000_0000 | (i << 12) | (i * 3);
    endfunction

    always_comb
        for (int i = 0; i < NUM_EXT; i++) tgt_rdata[i*DATA_W +: DATA_W] = lane_word(i + 1);

    subpage_demux #(.PAGE_BASE(BASE)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_access(input string req);
        logic [11:0] rel;
        logic [3:0] code;
        rel  = 12'(acc_addr - BASE);
        code = model[rel >> 8];
        chk({req, " R2 select"}, 64'(tgt_sel), (code == 0) ? 64'd0 : (64'd1 << (code - 1)));
        chk({req, " R7 unmapped"}, 64'(acc_unmapped), 64'(code == 0));
        chk({req, " R8 rdata"}, 64'(acc_rdata), (code == 0) ? 64'd0 : 64'(lane_word(int'(code))));
        chk({req, " R6 offset"}, 64'(tgt_addr), 64'(rel));
        chk({req, " R6 passthru"}, {29'd0, tgt_we, tgt_size, tgt_wdata}, {29'd0, acc_we, acc_size, acc_wdata});
    endtask

    task automatic do_access(input logic [11:0] rel, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = BASE + 32'(rel);
        acc_we    = 1'($urandom_range(0, 1));
        acc_size  = 2'($urandom_range(0, 2));
        acc_wdata = $urandom;
        #1 check_access(req);
    endtask

    function automatic bit range_good(int off, int len);
        return (len != 0) && (off + len <= 4096);
    endfunction

    task automatic apply_model(int off, int len, logic [3:0] tgt);
        for (int s = off >> 8; s <= (off + len - 1) >> 8; s++) model[s] = tgt;
    endtask

    task automatic do_cfg(input int off, input int len, input logic [3:0] tgt, input string req);
        bit good;
        good = range_good(off, len);
        @(negedge clk);
        acc_valid  = 1'b0;
        cfg_valid  = 1'b1;
        cfg_offset = 13'(off);
        cfg_len    = 13'(len);
        cfg_tgt    = tgt;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk({req, " R5 ack"}, 64'(cfg_ack), 64'(good));
        chk({req, " R4 err"}, 64'(cfg_err), 64'(!good));
        if (good) apply_model(off, len, tgt);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int s = 0; s < 16; s++) model[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: everything unmapped after reset
        @(negedge clk);
        chk("R1 idle sel", 64'(tgt_sel), 64'd0);
        chk("R10 idle ack/err", {62'd0, cfg_ack, cfg_err}, 64'd0);
        do_access(12'h000, "R1");
        do_access(12'hFFF, "R1");
        // R3: range crossing a slot boundary covers both slots
        do_cfg(12'h0FF, 2, 4'd3, "R3 cross");
        do_access(12'h0FF, "R3");
        do_access(12'h100, "R3");
        do_access(12'h200, "R3");
        // R3: last slot exactly
        do_cfg(12'hF00, 12'h100, 4'd15, "R3 last");
        do_access(12'hFFF, "R3");
        // R4: one byte past the page, zero length
        do_cfg(12'hF01, 12'h100, 4'd7, "R4 over");
        do_cfg(12'h400, 0, 4'd7, "R4 zero");
        do_cfg(4096, 1, 4'd7, "R4 offpage");
        do_access(12'hFFF, "R4");
        do_access(12'h400, "R4");
        // R5: same-cycle access sees old map, next cycle the new one
        @(negedge clk);
        cfg_valid = 1'b1; cfg_offset = 13'h200; cfg_len = 13'h100; cfg_tgt = 4'd9;
        acc_valid = 1'b1; acc_addr = BASE + 32'h210; acc_we = 1'b0; acc_size = 2'd2;
        #1 check_access("R5 old");
        @(negedge clk);
        cfg_valid = 1'b0;
        chk("R5 ack same", 64'(cfg_ack), 64'd1);
        apply_model(12'h200, 12'h100, 4'd9);
        #1 check_access("R5 new");
        // R9: whole page to one target, then back to default
        do_cfg(0, 4096, 4'd5, "R9 all");
        do_access(12'h7A0, "R9");
        do_cfg(12'h300, 12'h200, 4'd0, "R9 free");
        do_access(12'h3FF, "R9");
        do_access(12'h4FF, "R9");
        do_access(12'h500, "R9");
        // random mix
        for (int n = 0; n < 60; n++) begin
            do_cfg($urandom_range(0, 4200), $urandom_range(0, 1300),
                   4'($urandom_range(0, 15)), "R3 rand");
            for (int k = 0; k < 12; k++) do_access(12'($urandom), "R2 rand");
        end
        @(negedge clk);
        acc_valid = 1'b0;
        #1 chk("R2 idle sel", 64'(tgt_sel), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule